// File: doc/BRIEF.md
# Priority Memory-Map Chip-Select Decoder

This block compares each processor address against seven programmable windows and drives at most one registered chip select. Four windows cover program-memory blocks. The other three cover a RAM region, an internal I/O region and a peripheral I/O region. Each window is stored as a base, a mask and an enable, and is written one at a time through a small configuration port. An address hits a window when the address bits under the mask equal the base bits under the mask.

RAM and I/O windows may sit on top of program-memory space. Where they do, they take the access, and the program memory underneath cannot be reached. Two kinds of overlap are illegal: two program-memory windows overlapping each other, and two windows among RAM, internal I/O and peripheral I/O overlapping each other. A program-memory window that spans more addresses than one program-memory block (`PM_BLK_KB` kilobytes) is also illegal. The error flag is recomputed from the stored configuration, so it clears once the configuration has been made legal again.

Top module: `memsel_decoder`

## Requirements
- R1: When `addr_vld` is high at a clock edge, the select of the window hit by `addr` is high in the following cycle. A window is hit when it is enabled and `(addr & mask) == (base & mask)`.
- R2: In the cycle after an edge where `addr_vld` is low, or where no enabled window is hit, every select is low. There is no default target.
- R3: At most one of the seven selects is high in any cycle.
- R4: A RAM, internal I/O or peripheral I/O hit suppresses every program-memory select for that address. Among program-memory windows, the lowest index wins.
- R5: The peripheral I/O window is hit only while the peripheral-mode bit is 1. That bit is written with `cfg_sel` = 7 and takes the value of `cfg_en`.
- R6: An enabled program-memory window whose mask has fewer than `ADDR_W - log2(PM_BLK_KB*1024)` one bits is oversized, and it sets `cfg_err`.
- R7: Two enabled program-memory windows that share any address set `cfg_err`.
- R8: Two windows among RAM, internal I/O and peripheral I/O that share any address set `cfg_err`. The peripheral window counts only while the peripheral-mode bit is 1.
- R9: A RAM or I/O window that overlaps a program-memory window does not set `cfg_err`.
- R10: `cfg_err` follows the stored configuration one cycle after each write, and it clears once a later write makes the configuration legal.
- R11: After reset, all windows are disabled, the peripheral-mode bit is 0, and all selects and `cfg_err` are low.
- R12: A write with `cfg_we` high loads the window chosen by `cfg_sel`: 0 to 3 are program-memory blocks 0 to 3, 4 is RAM, 5 is internal I/O, and 6 is peripheral I/O. It stores `cfg_base`, `cfg_mask` and `cfg_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_vld | input | 1 | Address strobe |
| addr | input | ADDR_W | Processor address |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 3 | Window index, or 7 for the peripheral-mode bit |
| cfg_base | input | ADDR_W | Window base |
| cfg_mask | input | ADDR_W | Window mask (ones are compared) |
| cfg_en | input | 1 | Window enable, or the peripheral-mode bit value |
| pm_sel | output | 4 | Program-memory block selects |
| ram_sel | output | 1 | RAM select |
| iio_sel | output | 1 | Internal I/O select |
| pio_sel | output | 1 | Peripheral I/O select |
| cfg_err | output | 1 | Illegal configuration flag |

## Verification
The assertions check four properties on every cycle:
- the selects are never more than one-hot;
- the selects go quiet after an idle strobe;
- a program-memory select never comes out for an address that hit RAM or I/O;
- the peripheral select needs the mode bit, and an oversized program window always raises the flag.

Only the bench's scenarios can show the rest:
- that the correct window is chosen for a given address;
- that overlaps inside each group are flagged while cross-group overlaps are not;
- that the flag clears after a legal rewrite.

// File: rtl/memsel_decoder.sv
module memsel_decoder #(
  parameter int ADDR_W    = 16,
  parameter int PM_BLK_KB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_vld,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_mask,
  input  logic              cfg_en,
  output logic [3:0]        pm_sel,
  output logic              ram_sel,
  output logic              iio_sel,
  output logic              pio_sel,
  output logic              cfg_err
);

  localparam int NWIN     = 7;
  localparam int BLK_AW   = $clog2(PM_BLK_KB * 1024);
  localparam int MIN_ONES = ADDR_W - BLK_AW;

  logic [ADDR_W-1:0] base_q [NWIN];
  logic [ADDR_W-1:0] mask_q [NWIN];
  logic [NWIN-1:0]   en_q, act, hit;
  logic              pmode_q;
  logic [NWIN-1:0]   sel_d, sel_q;
  logic              hi_hit, over_any, err_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      pmode_q <= 1'b0;
      for (int i = 0; i < NWIN; i++) begin
        base_q[i] <= '0;
        mask_q[i] <= '0;
      end
    end else if (cfg_we) begin
      if (cfg_sel == 3'd7) pmode_q <= cfg_en;
      for (int i = 0; i < NWIN; i++)
        if (cfg_sel == 3'(i)) begin
          base_q[i] <= cfg_base;
          mask_q[i] <= cfg_mask;
          en_q[i]   <= cfg_en;
        end
    end
  end

  assign act = {en_q[6] & pmode_q, en_q[5:0]};

  always_comb
    for (int i = 0; i < NWIN; i++)
      hit[i] = act[i] && ((addr & mask_q[i]) == (base_q[i] & mask_q[i]));

  assign hi_hit = |hit[6:4];

  always_comb begin
    sel_d = '0;
    if (addr_vld) begin
      if (hit[4])      sel_d[4] = 1'b1;
      else if (hit[5]) sel_d[5] = 1'b1;
      else if (hit[6]) sel_d[6] = 1'b1;
      else begin
        for (int i = 3; i >= 0; i--)
          if (hit[i]) begin
            sel_d[3:0] = '0;
            sel_d[i]   = 1'b1;
          end
      end
    end
  end

  always_comb begin
    over_any = 1'b0;
    for (int i = 0; i < 4; i++)
      if (en_q[i] && ($countones(mask_q[i]) < MIN_ONES)) over_any = 1'b1;
  end

  always_comb begin
    err_c = over_any;
    for (int i = 0; i < 4; i++)
      for (int j = i + 1; j < 4; j++)
        if (act[i] && act[j] && (((base_q[i] ^ base_q[j]) & mask_q[i] & mask_q[j]) == '0))
          err_c = 1'b1;
    for (int i = 4; i < NWIN; i++)
      for (int j = i + 1; j < NWIN; j++)
        if (act[i] && act[j] && (((base_q[i] ^ base_q[j]) & mask_q[i] & mask_q[j]) == '0))
          err_c = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      cfg_err <= 1'b0;
    end else begin
      sel_q   <= sel_d;
      cfg_err <= err_c;
    end
  end

  assign pm_sel  = sel_q[3:0];
  assign ram_sel = sel_q[4];
  assign iio_sel = sel_q[5];
  assign pio_sel = sel_q[6];

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pio_sel, iio_sel, ram_sel, pm_sel})); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_vld |=> ({pio_sel, iio_sel, ram_sel, pm_sel} == '0)); // R2
  AST_PM_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (|pm_sel) |-> !($past(addr_vld) && $past(hi_hit))); // R4
  AST_PIO_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    pio_sel |-> $past(pmode_q)); // R5
  AST_OVERSIZE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    over_any |=> cfg_err); // R6

endmodule

// File: tb/memsel_decoder_bench.sv
module memsel_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int MIN_ONES = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic addr_vld = 1'b0, cfg_we = 1'b0, cfg_en = 1'b0;
  logic [AW-1:0] addr = '0, cfg_base = '0, cfg_mask = '0;
  logic [2:0] cfg_sel = '0;
  logic [3:0] pm_sel;
  logic ram_sel, iio_sel, pio_sel, cfg_err;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  logic [AW-1:0] m_base [7];
  logic [AW-1:0] m_mask [7];
  logic [6:0] m_en = '0;
  logic m_mode = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  memsel_decoder #(.ADDR_W(AW), .PM_BLK_KB(8)) u_memsel_decoder (
    .clk(clk), .rst_n(rst_n), .addr_vld(addr_vld), .addr(addr),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_base(cfg_base), .cfg_mask(cfg_mask),
    .cfg_en(cfg_en), .pm_sel(pm_sel), .ram_sel(ram_sel), .iio_sel(iio_sel),
    .pio_sel(pio_sel), .cfg_err(cfg_err));

  function automatic logic [6:0] live();
    return {m_en[6] & m_mode, m_en[5:0]};
  endfunction

  function automatic logic [6:0] exp_sel(logic [AW-1:0] a);
    logic [6:0] h = '0;
    logic [6:0] lv = live();
    for (int i = 0; i < 7; i++)
      h[i] = lv[i] && ((a & m_mask[i]) == (m_base[i] & m_mask[i]));
    if (h[4]) return 7'b0010000;
    if (h[5]) return 7'b0100000;
    if (h[6]) return 7'b1000000;
    for (int i = 0; i < 4; i++) if (h[i]) return 7'(1 << i);
    return '0;
  endfunction

  function automatic bit shares(int i, int j);
    return ((m_base[i] ^ m_base[j]) & m_mask[i] & m_mask[j]) == '0;
  endfunction

  function automatic logic exp_err();
    logic [6:0] lv = live();
    for (int i = 0; i < 4; i++)
      if (lv[i] && $countones(m_mask[i]) < MIN_ONES) return 1'b1;
    for (int i = 0; i < 4; i++)
      for (int j = i + 1; j < 4; j++)
        if (lv[i] && lv[j] && shares(i, j)) return 1'b1;
    for (int i = 4; i < 7; i++)
      for (int j = i + 1; j < 7; j++)
        if (lv[i] && lv[j] && shares(i, j)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  // R12 write then R10 error follow-up
  task automatic wr(logic [2:0] s, logic [AW-1:0] b, logic [AW-1:0] m, logic e, string tag);
    cfg_we = 1; cfg_sel = s; cfg_base = b; cfg_mask = m; cfg_en = e;
    @(negedge clk);
    cfg_we = 0;
    if (s == 3'd7) m_mode = e;
    else begin m_base[s] = b; m_mask[s] = m; m_en[s] = e; end
    @(negedge clk);
    chk(tag, 32'(cfg_err), 32'(exp_err()));
  endtask

  task automatic probe(logic [AW-1:0] a, string tag);
    addr_vld = 1; addr = a;
    @(negedge clk);
    addr_vld = 0;
    chk(tag, 32'({pio_sel, iio_sel, ram_sel, pm_sel}), 32'(exp_sel(a)));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL R1 watchdog actual=%0d expected=done", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4021));
    for (int i = 0; i < 7; i++) begin m_base[i] = '0; m_mask[i] = '0; end
    repeat (3) @(negedge clk);
    chk("R11 sel", 32'({pio_sel, iio_sel, ram_sel, pm_sel}), 0);
    chk("R11 err", 32'(cfg_err), 0);
    rst_n = 1;
    @(negedge clk);
    probe(16'h1234, "R11 R2 disabled");
    wr(3'd0, 16'h0000, 16'hE000, 1, "R12 pm0");
    probe(16'h1234, "R1 pm0");
    wr(3'd4, 16'h1000, 16'hF800, 1, "R9 ram over pm0");
    chk("R9 flag", 32'(cfg_err), 0);
    probe(16'h1234, "R4 ram wins");
    probe(16'h0800, "R1 pm0 visible");
    probe(16'hF000, "R2 no hit");
    wr(3'd1, 16'h2000, 16'hC000, 1, "R6 oversize");
    chk("R6 flag", 32'(cfg_err), 1);
    wr(3'd1, 16'h2000, 16'hE000, 1, "R10 fixed");
    chk("R10 clear", 32'(cfg_err), 0);
    wr(3'd2, 16'h2000, 16'hF000, 1, "R7 overlap");
    chk("R7 flag", 32'(cfg_err), 1);
    wr(3'd2, 16'h4000, 16'hE000, 1, "R10 moved");
    probe(16'h4567, "R1 pm2");
    wr(3'd6, 16'h8000, 16'hFF00, 1, "R12 pio");
    probe(16'h8010, "R5 mode off");
    wr(3'd7, 16'h0000, 16'h0000, 1, "R5 mode on");
    probe(16'h8010, "R5 pio");
    wr(3'd5, 16'h1000, 16'hFF00, 1, "R8 overlap");
    chk("R8 flag", 32'(cfg_err), 1);
    probe(16'h1010, "R3 R4 overlap");
    wr(3'd5, 16'h9000, 16'hFF00, 1, "R10 iio moved");
    probe(16'h9001, "R1 iio");
    wr(3'd3, 16'h6000, 16'hE000, 0, "R12 pm3 off");
    probe(16'h6001, "R2 disabled");
    for (int it = 0; it < 600; it++) begin
      if ($urandom % 3 == 0) begin
        automatic int k = 8 + int'($urandom % 8);
        automatic logic [AW-1:0] m = 16'hFFFF << k;
        wr(3'($urandom % 8), 16'($urandom), m, 1'($urandom % 4 != 0), "R6 R7 R8 R10 rand");
      end
      for (int p = 0; p < 4; p++) begin
        automatic logic [AW-1:0] a = 16'($urandom);
        if (p < 2) a = m_base[$urandom % 7] ^ 16'($urandom % 256);
        probe(a, "R1 R3 R4 rand");
      end
    end
    summary();
    $finish;
  end
endmodule